// File: doc/BRIEF.md
# Pipeline Exception Capture Unit

This block watches the four stages of a simple in-order pipeline (fetch, decode, execute, memory) and an external interrupt line. It selects the single event to take in a cycle. It records the event's cause code and the program counter of the instruction involved, then on the next cycle sends a one-cycle flush mask and a redirect to a handler address.

The handler address comes from one of two modes. The first is a single fixed entry point. The second is a vectored entry, where the cause code selects a slot at a fixed stride above the base. After a capture, the unit stays in a handler state and ignores new events until software pulses the clear input. The recorded cause and saved PC stay readable on the outputs for the whole handler run.

Top module: `exc_capture`

## Requirements
- R1: After a synchronous reset, flush_mask, redirect_valid, redirect_pc, cause, epc and in_handler are all zero.
- R2: An event taken at clock edge N shows on the outputs after edge N+1 (one register stage). At that point redirect_valid is high for exactly one cycle and in_handler goes to 1.
- R3: When several stages raise exceptions in the same cycle, the oldest wins: memory first, then execute, then decode, then fetch. epc receives the PC of the winning stage.
- R4: Cause codes are 1 illegal opcode (decode), 2 overflow and 3 divide by zero (execute), 4 fetch page fault (fetch), 5 data page fault and 6 protection violation (memory). Within a stage, divide by zero beats overflow and protection violation beats data page fault.
- R5: flush_mask bit 3 is memory, bit 2 execute, bit 1 decode and bit 0 fetch. On a taken exception, the bits of the winning stage and of every younger stage are set, and flush_mask is zero in all other cycles.
- R6: An interrupt has lower priority than any exception. A taken interrupt records cause 0, saves the memory-stage PC and sets all four flush_mask bits.
- R7: With vec_mode low at capture, redirect_pc is the base address (default 0x100).
- R8: With vec_mode high at capture, redirect_pc is the base plus cause×16.
- R9: While in_handler is 1, no event is taken. cause, epc and redirect_pc keep their values, and flush_mask and redirect_valid stay zero.
- R10: clear asserted while in_handler is 1 lowers in_handler one cycle later. clear asserted while in_handler is 0 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| vec_mode | input | 1 | 1 = vectored handler entry, 0 = fixed entry |
| clear | input | 1 | Handler finished; lowers in_handler |
| irq | input | 1 | External interrupt request |
| if_pfault | input | 1 | Fetch-stage page fault |
| id_illegal | input | 1 | Decode-stage illegal opcode |
| ex_ovf | input | 1 | Execute-stage arithmetic overflow |
| ex_div0 | input | 1 | Execute-stage divide by zero |
| mem_pfault | input | 1 | Memory-stage data page fault |
| mem_prot | input | 1 | Memory-stage protection violation |
| if_pc | input | XLEN | PC in fetch |
| id_pc | input | XLEN | PC in decode |
| ex_pc | input | XLEN | PC in execute |
| mem_pc | input | XLEN | PC in memory |
| flush_mask | output | 4 | Per-stage flush pulse |
| redirect_valid | output | 1 | One-cycle redirect strobe |
| redirect_pc | output | XLEN | Handler target address |
| cause | output | 3 | Recorded cause code |
| epc | output | XLEN | Saved PC of the event |
| in_handler | output | 1 | Handler-active flag |

## Verification
The bench uses several directed patterns:
- All stages faulting together, to show that the oldest stage wins.
- Both execute flags together, and both memory flags together, to show the order within a stage.
- An interrupt together with a fetch fault, to confirm that exceptions beat interrupts.
- An interrupt alone, to confirm the memory-stage PC and the full flush.
- New faults during a handler run, to show that the saved state is not overwritten.

Random flag patterns, with clear pulses at random points and vec_mode toggling, then mix captures, blocked cycles and clears. This separates the fixed and vectored targets and shows that a clear given outside a handler does nothing.

// File: rtl/exc_pkg.sv
package exc_pkg;
  localparam int CAUSE_W    = 3;
  localparam int NUM_STAGES = 4;
  localparam int STAGE_W    = $clog2(NUM_STAGES);

  // stage indices: higher index is an older instruction
  localparam int ST_IF  = 0;
  localparam int ST_ID  = 1;
  localparam int ST_EX  = 2;
  localparam int ST_MEM = 3;

  localparam logic [CAUSE_W-1:0] C_IRQ     = 3'd0;
  localparam logic [CAUSE_W-1:0] C_ILLEGAL = 3'd1;
  localparam logic [CAUSE_W-1:0] C_OVF     = 3'd2;
  localparam logic [CAUSE_W-1:0] C_DIV0    = 3'd3;
  localparam logic [CAUSE_W-1:0] C_IPF     = 3'd4;
  localparam logic [CAUSE_W-1:0] C_DPF     = 3'd5;
  localparam logic [CAUSE_W-1:0] C_PROT    = 3'd6;
endpackage

// File: rtl/exc_prio.sv
module exc_prio #(
  parameter int NST = 4,
  localparam int IW = (NST > 1) ? $clog2(NST) : 1
) (
  input  logic [NST-1:0] req,
  output logic           hit,
  output logic [IW-1:0]  idx,
  output logic [NST-1:0] mask
);
  // oldest (highest index) request wins; later loop passes overwrite
  always_comb begin
    hit = 1'b0;
    idx = '0;
    for (int i = 0; i < NST; i++) begin
      if (req[i]) begin
        hit = 1'b1;
        idx = IW'(i);
      end
    end
  end

  // flush the winner and every younger stage
  for (genvar g = 0; g < NST; g++) begin : g_mask
    assign mask[g] = hit && (IW'(g) <= idx);
  end

  always_comb begin
    if (hit) begin
      p_winner_is_requester_r3: assert (req[idx] && mask[idx])
        else $error("R3 winner not a requesting stage");
    end
  end
endmodule

// File: rtl/exc_vector.sv
module exc_vector #(
  parameter int XLEN      = 32,
  parameter int CAUSE_W   = 3,
  parameter int VEC_SHIFT = 4
) (
  input  logic [XLEN-1:0]    base,
  input  logic               vec_mode,
  input  logic [CAUSE_W-1:0] cause,
  output logic [XLEN-1:0]    target
);
  logic [XLEN-1:0] offset;
  assign offset = XLEN'(cause) << VEC_SHIFT;
  assign target = vec_mode ? (base + offset) : base;
endmodule

// File: rtl/exc_capture.sv
module exc_capture
  import exc_pkg::*;
#(
  parameter int              XLEN         = 32,
  parameter logic [XLEN-1:0] HANDLER_BASE = 32'h0000_0100,
  parameter int              VEC_SHIFT    = 4
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  vec_mode,
  input  logic                  clear,
  input  logic                  irq,
  input  logic                  if_pfault,
  input  logic                  id_illegal,
  input  logic                  ex_ovf,
  input  logic                  ex_div0,
  input  logic                  mem_pfault,
  input  logic                  mem_prot,
  input  logic [XLEN-1:0]       if_pc,
  input  logic [XLEN-1:0]       id_pc,
  input  logic [XLEN-1:0]       ex_pc,
  input  logic [XLEN-1:0]       mem_pc,
  output logic [NUM_STAGES-1:0] flush_mask,
  output logic                  redirect_valid,
  output logic [XLEN-1:0]       redirect_pc,
  output logic [CAUSE_W-1:0]    cause,
  output logic [XLEN-1:0]       epc,
  output logic                  in_handler
);
  logic [NUM_STAGES-1:0] sreq;
  logic [XLEN-1:0]       spc    [NUM_STAGES];
  logic [CAUSE_W-1:0]    scause [NUM_STAGES];

  assign sreq[ST_IF]  = if_pfault;
  assign sreq[ST_ID]  = id_illegal;
  assign sreq[ST_EX]  = ex_div0 | ex_ovf;
  assign sreq[ST_MEM] = mem_prot | mem_pfault;

  assign spc[ST_IF]  = if_pc;
  assign spc[ST_ID]  = id_pc;
  assign spc[ST_EX]  = ex_pc;
  assign spc[ST_MEM] = mem_pc;

  always_comb begin
    scause[ST_IF]  = C_IPF;
    scause[ST_ID]  = C_ILLEGAL;
    scause[ST_EX]  = ex_div0  ? C_DIV0 : C_OVF;
    scause[ST_MEM] = mem_prot ? C_PROT : C_DPF;
  end

  logic                  hit;
  logic [STAGE_W-1:0]    win;
  logic [NUM_STAGES-1:0] win_mask;

  exc_prio #(.NST(NUM_STAGES)) u_prio (
    .req  (sreq),
    .hit  (hit),
    .idx  (win),
    .mask (win_mask)
  );

  logic                  take;
  logic [CAUSE_W-1:0]    nxt_cause;
  logic [XLEN-1:0]       nxt_pc;
  logic [NUM_STAGES-1:0] nxt_mask;
  logic [XLEN-1:0]       nxt_target;

  assign take      = !in_handler && (hit || irq);
  assign nxt_cause = hit ? scause[win] : C_IRQ;
  assign nxt_pc    = hit ? spc[win]    : mem_pc;
  assign nxt_mask  = hit ? win_mask    : '1;

  exc_vector #(.XLEN(XLEN), .CAUSE_W(CAUSE_W), .VEC_SHIFT(VEC_SHIFT)) u_vec (
    .base     (HANDLER_BASE),
    .vec_mode (vec_mode),
    .cause    (nxt_cause),
    .target   (nxt_target)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      flush_mask     <= '0;
      redirect_valid <= 1'b0;
      redirect_pc    <= '0;
      cause          <= '0;
      epc            <= '0;
      in_handler     <= 1'b0;
    end else begin
      flush_mask     <= take ? nxt_mask : '0;
      redirect_valid <= take;
      if (take) begin
        cause       <= nxt_cause;
        epc         <= nxt_pc;
        redirect_pc <= nxt_target;
        in_handler  <= 1'b1;
      end else if (clear) begin
        in_handler  <= 1'b0;
      end
    end
  end

  // R2: a redirect always comes with the handler flag set
  p_redirect_sets_flag_r2: assert property (@(posedge clk) disable iff (rst)
    redirect_valid |-> in_handler);
  // R2: redirect is a single-cycle pulse
  p_redirect_pulse_r2: assert property (@(posedge clk) disable iff (rst)
    redirect_valid |=> !redirect_valid);
  // R5: a redirect always flushes at least the fetch stage
  p_flush_with_redirect_r5: assert property (@(posedge clk) disable iff (rst)
    redirect_valid |-> flush_mask[ST_IF]);
  // R5: no flush without a redirect
  p_flush_only_on_redirect_r5: assert property (@(posedge clk) disable iff (rst)
    !redirect_valid |-> (flush_mask == '0));
  // R9: saved state frozen while in the handler
  p_hold_epc_r9: assert property (@(posedge clk) disable iff (rst)
    in_handler |=> ($stable(epc) && $stable(cause) && !redirect_valid));
  // R10: flag only drops on clear
  p_flag_held_r10: assert property (@(posedge clk) disable iff (rst)
    (in_handler && !clear) |=> in_handler);
endmodule

// File: tb/exc_capture_bench.sv
module exc_capture_bench;
  localparam int CLK_PERIOD = 10;
  localparam int XLEN = 32;
  localparam logic [XLEN-1:0] BASE = 32'h0000_0100;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic vec_mode = 1'b0, clear = 1'b0, irq = 1'b0;
  logic if_pfault = 1'b0, id_illegal = 1'b0, ex_ovf = 1'b0, ex_div0 = 1'b0;
  logic mem_pfault = 1'b0, mem_prot = 1'b0;
  logic [XLEN-1:0] if_pc = '0, id_pc = '0, ex_pc = '0, mem_pc = '0;
  logic [3:0]      flush_mask;
  logic            redirect_valid;
  logic [XLEN-1:0] redirect_pc;
  logic [2:0]      cause;
  logic [XLEN-1:0] epc;
  logic            in_handler;

  always #(CLK_PERIOD/2) clk = ~clk;

  exc_capture u_exc_capture (
    .clk(clk), .rst(rst), .vec_mode(vec_mode), .clear(clear), .irq(irq),
    .if_pfault(if_pfault), .id_illegal(id_illegal), .ex_ovf(ex_ovf),
    .ex_div0(ex_div0), .mem_pfault(mem_pfault), .mem_prot(mem_prot),
    .if_pc(if_pc), .id_pc(id_pc), .ex_pc(ex_pc), .mem_pc(mem_pc),
    .flush_mask(flush_mask), .redirect_valid(redirect_valid),
    .redirect_pc(redirect_pc), .cause(cause), .epc(epc), .in_handler(in_handler)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // reference model state
  logic [3:0]      m_flush = '0;
  logic            m_redir = 1'b0;
  logic [XLEN-1:0] m_tgt = '0;
  logic [2:0]      m_cause = '0;
  logic [XLEN-1:0] m_epc = '0;
  logic            m_inh = 1'b0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // R3/R4/R6 expected winner from the requirement priority list
  function automatic logic [2:0] exp_cause();
    if (mem_prot)   return 3'd6;
    if (mem_pfault) return 3'd5;
    if (ex_div0)    return 3'd3;
    if (ex_ovf)     return 3'd2;
    if (id_illegal) return 3'd1;
    if (if_pfault)  return 3'd4;
    return 3'd0;
  endfunction

  function automatic logic [3:0] exp_mask();
    if (mem_prot || mem_pfault) return 4'b1111;
    if (ex_div0 || ex_ovf)      return 4'b0111;
    if (id_illegal)             return 4'b0011;
    if (if_pfault)              return 4'b0001;
    return 4'b1111;
  endfunction

  function automatic logic [XLEN-1:0] exp_pc();
    if (mem_prot || mem_pfault) return mem_pc;
    if (ex_div0 || ex_ovf)      return ex_pc;
    if (id_illegal)             return id_pc;
    if (if_pfault)              return if_pc;
    return mem_pc;
  endfunction

  // inputs already driven; advance one cycle, update model, compare
  task automatic step();
    logic any, take, clr;
    any = if_pfault | id_illegal | ex_ovf | ex_div0 | mem_pfault | mem_prot | irq;
    take = !m_inh && any;
    clr = clear;
    m_flush = take ? exp_mask() : 4'b0;
    m_redir = take;
    if (take) begin
      m_cause = exp_cause();
      m_epc   = exp_pc();
      m_tgt   = vec_mode ? BASE + {m_cause, 4'b0} : BASE;
      m_inh   = 1'b1;
    end else if (clr) m_inh = 1'b0;
    @(posedge clk);
    @(negedge clk);
    chk("R5 flush_mask", 32'(flush_mask), 32'(m_flush));
    chk("R2 redirect_valid", 32'(redirect_valid), 32'(m_redir));
    chk(vec_mode ? "R8 redirect_pc" : "R7 redirect_pc", redirect_pc, m_tgt);
    chk(m_cause == 3'd0 ? "R6 cause" : "R4 cause", 32'(cause), 32'(m_cause));
    chk("R3 epc", epc, m_epc);
    chk(clr ? "R10 in_handler" : "R9 in_handler", 32'(in_handler), 32'(m_inh));
  endtask

  task automatic idle();
    {irq, if_pfault, id_illegal, ex_ovf, ex_div0, mem_pfault, mem_prot, clear} = '0;
  endtask

  task automatic set_pcs();
    if_pc = 32'h1000; id_pc = 32'h0ffc; ex_pc = 32'h0ff8; mem_pc = 32'h0ff4;
  endtask

  initial begin
    process_seed: begin
      int unused;
      unused = $urandom(32'd2024);
    end
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    chk("R1 flush", 32'(flush_mask), 0);
    chk("R1 redirect", 32'(redirect_valid), 0);
    chk("R1 pc", redirect_pc, 0);
    chk("R1 cause", 32'(cause), 0);
    chk("R1 epc", epc, 0);
    chk("R1 flag", 32'(in_handler), 0);

    set_pcs();
    // R10: clear outside handler has no effect
    idle(); clear = 1'b1; step();
    // R3: all stages at once, memory wins; R4 protection beats page fault
    idle(); vec_mode = 1'b1;
    {if_pfault, id_illegal, ex_div0, mem_pfault, mem_prot} = '1; step();
    // R9: new fault inside handler is ignored
    idle(); id_illegal = 1'b1; irq = 1'b1; step();
    idle(); step();
    // R10: clear ends the handler
    idle(); clear = 1'b1; step();
    // R4: divide by zero beats overflow
    idle(); ex_div0 = 1'b1; ex_ovf = 1'b1; step();
    idle(); clear = 1'b1; step();
    // R6: interrupt loses to fetch fault
    idle(); irq = 1'b1; if_pfault = 1'b1; step();
    idle(); clear = 1'b1; step();
    // R6/R7: interrupt alone, fixed entry
    idle(); vec_mode = 1'b0; irq = 1'b1; step();
    idle(); clear = 1'b1; step();
    // R8: vectored data page fault
    idle(); vec_mode = 1'b1; mem_pfault = 1'b1; step();
    idle(); clear = 1'b1; step();

    // random mix
    for (int n = 0; n < 3000; n++) begin
      idle();
      vec_mode   = ($urandom % 2) == 0;
      if_pfault  = ($urandom % 7) == 0;
      id_illegal = ($urandom % 7) == 0;
      ex_ovf     = ($urandom % 8) == 0;
      ex_div0    = ($urandom % 8) == 0;
      mem_pfault = ($urandom % 9) == 0;
      mem_prot   = ($urandom % 9) == 0;
      irq        = ($urandom % 6) == 0;
      clear      = ($urandom % 3) == 0;
      if_pc = $urandom; id_pc = $urandom; ex_pc = $urandom; mem_pc = $urandom;
      step();
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule